// File: doc/BRIEF.md
# Transmit DMA Queue Command Controller

This block turns processor command writes into per-queue control for a packet DMA engine. The engine has two transmit queues and one receive channel. For each transmit queue the block holds a start bit, a stop bit and a run state. It drives a descriptor walker through a fetch request channel and a descriptor acceptance channel, and it follows frame completion and failed-attempt pulses from the walker. It produces single-cycle end-of-queue, retry and retransmit-limit events, which are meant to feed a sticky cause register outside the block.

A stop is graceful: it takes effect only when no frame is being sent. An abort is immediate: every queue drops to idle, no descriptor is closed and no event fires. The abort busy flag stays high until the engine reports that it is idle, then clears itself. The receive channel has an enable bit and an abort bit that follow the same busy-until-idle rule.

Both walker channels are valid/ready. Once the block raises `fetch_valid` for a queue, it holds the request and its address unchanged until `fetch_ready` is seen, unless an abort withdraws it. A descriptor is taken only in a cycle where `desc_valid` and `desc_ready` are both high. `desc_ready` is high only while the queue waits for its next descriptor and no stop is pending. The walker may hold `desc_valid` as long as it needs to.

Top module: `dma_qcmd_ctrl`

## Requirements
- R1: A write with start bit q = 1, stop bit q = 0 and no abort sets start bit q and clears stop bit q. If queue q is idle, in the next cycle `q_running[q]`=1 and `fetch_valid[q]`=1, with `fetch_addr` slice q equal to the first-descriptor pointer slice q.
- R2: A write with stop bit q = 1 sets stop bit q and clears start bit q, even when start bit q is also 1 in the same write. A write of 0 to a start or stop bit changes nothing.
- R3: While `fetch_valid[q]`=1 and `fetch_ready[q]`=0, the request and its address hold in the next cycle. `desc_ready[q]` is 1 only after the fetch is accepted and while the queue waits for a descriptor.
- R4: A stop that arrives while a frame is being sent does not end the queue until `frame_done[q]`. One cycle after that pulse, `tx_end[q]`=1 for one cycle and `q_running[q]`=0.
- R5: A stop written while queue q waits for a descriptor ends the queue one cycle after the stop bit is set, with a `tx_end[q]` pulse. A stop written while the queue is idle produces no event.
- R6: A start written while a stop is pending cancels the stop. The queue keeps running past the frame end, with no `tx_end` and no new fetch.
- R7: A descriptor accepted with `desc_dma_own[q]`=0 (0 means processor-owned, 1 means DMA-owned) is the end of the chain. One cycle later `tx_end[q]`=1 and `q_running[q]`=0.
- R8: With `retry_limit` L > 0, each `tx_fail[q]` during a frame gives a `retry_req[q]` pulse one cycle later for the first L failures. Failure L+1 instead gives a `close_rl[q]` pulse, and the queue waits for the next descriptor. The failure count restarts at each frame end.
- R9: With `retry_limit` = 0, every failure gives `retry_req` and none gives `close_rl`.
- R10: An abort-transmit write makes, in the next cycle, all `q_running`=0, all `fetch_valid`=0, all start bits 0 and `tx_abort_busy`=1, with no `tx_end` or `close_rl`. `tx_abort_busy` stays 1 while `tx_engine_idle`=0 and clears one cycle after it is seen as 1.
- R11: Start writes made while `tx_abort_busy`=1, or in the same write as an abort, are ignored.
- R12: A receive-enable write sets `rx_enable`. An abort-receive write sets `rx_abort_busy`. One cycle after `rx_engine_idle` is seen with the busy flag set, both `rx_enable` and `rx_abort_busy` are 0.
- R13: The queues are independent. Ending one queue does not change the other queue's run state or events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_start | input | NQ | Start bit per queue |
| cmd_stop | input | NQ | Stop bit per queue |
| cmd_abort_tx | input | 1 | Abort transmit |
| cmd_rx_en | input | 1 | Receive enable |
| cmd_abort_rx | input | 1 | Abort receive |
| retry_limit | input | RW | Maximum retransmissions, 0 = unlimited |
| first_ptr | input | NQ*AW | First-descriptor pointer per queue |
| tx_engine_idle | input | 1 | Transmit engine has reached idle |
| rx_engine_idle | input | 1 | Receive engine has reached idle |
| fetch_valid | output | NQ | Fetch request valid |
| fetch_ready | input | NQ | Fetch request accepted |
| fetch_addr | output | NQ*AW | Fetch address per queue |
| desc_valid | input | NQ | Descriptor presented |
| desc_dma_own | input | NQ | Descriptor owner, 1 = DMA |
| desc_ready | output | NQ | Descriptor accepted |
| frame_done | input | NQ | Frame finished sending |
| tx_fail | input | NQ | Send attempt failed |
| retry_req | output | NQ | Retransmit pulse |
| close_rl | output | NQ | Close with retransmit-limit error pulse |
| tx_end | output | NQ | End-of-queue event pulse |
| q_running | output | NQ | Queue run state |
| q_start_bit | output | NQ | Start bit readback |
| q_stop_bit | output | NQ | Stop bit readback |
| tx_abort_busy | output | 1 | Abort transmit in progress |
| rx_enable | output | 1 | Receive enabled |
| rx_abort_busy | output | 1 | Abort receive in progress |

## Verification
Command bits, the run state, the fetch request and the abort flags change one cycle after the write edge. The bench drives each write for one clock and reads the result at the next falling edge. Events (`tx_end`, `retry_req`, `close_rl`) are registered and are due one cycle after the walker pulse or descriptor acceptance that causes them; the bench samples them at the falling edge just after that clock.

A stop written while the queue waits for a descriptor takes two cycles: one to set the bit and one to end the queue. Busy flags clear one cycle after the idle input is first seen high. The bench counts retry and limit pulses at every falling edge across a burst of failures, so that each count matches the table entry exactly.

// File: rtl/dma_qcmd_pkg.sv
package dma_qcmd_pkg;
  typedef enum logic [1:0] {
    TQ_IDLE  = 2'd0,
    TQ_FETCH = 2'd1,
    TQ_WDESC = 2'd2,
    TQ_SEND  = 2'd3
  } txq_state_e;
endpackage

// File: rtl/dma_retry_ctr.sv
module dma_retry_ctr #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fail,
  input  logic [RW-1:0] limit,
  output logic          retry_now,
  output logic          hit_now
);
  localparam logic [RW-1:0] CNT_MAX = {RW{1'b1}};
  logic [RW-1:0] cnt;

  // limit 0 never hits; otherwise the failure after L retries closes
  assign hit_now   = fail && (limit != '0) && (cnt == limit);
  assign retry_now = fail && !hit_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || hit_now) begin
      cnt <= '0;
    end else if (retry_now && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dma_txq_fsm.sv
module dma_txq_fsm
  import dma_qcmd_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_go,
  input  logic          stop_pend,
  input  logic          abort_go,
  input  logic [AW-1:0] first_ptr,
  input  logic [RW-1:0] retry_limit,
  input  logic          fetch_ready,
  input  logic          desc_valid,
  input  logic          desc_own,
  input  logic          frame_done,
  input  logic          tx_fail,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  output logic          desc_ready,
  output logic          retry_req,
  output logic          close_rl,
  output logic          tx_end,
  output logic          running
);
  txq_state_e    st;
  logic [AW-1:0] ptr;
  logic          in_send;
  logic          fail_in;
  logic          retry_now;
  logic          hit_now;
  logic          frame_end;
  logic          ctr_clr;

  assign in_send   = (st == TQ_SEND);
  assign fail_in   = in_send && tx_fail && !frame_done;
  assign frame_end = in_send && (frame_done || hit_now);
  assign ctr_clr   = abort_go || frame_end || ((st == TQ_IDLE) && start_go);

  dma_retry_ctr #(.RW(RW)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctr_clr),
    .fail      (fail_in),
    .limit     (retry_limit),
    .retry_now (retry_now),
    .hit_now   (hit_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TQ_IDLE;
      ptr       <= '0;
      tx_end    <= 1'b0;
      retry_req <= 1'b0;
      close_rl  <= 1'b0;
    end else begin
      tx_end    <= 1'b0;
      retry_req <= retry_now && !abort_go;
      close_rl  <= hit_now && !abort_go;
      if (abort_go) begin
        st <= TQ_IDLE;
      end else begin
        case (st)
          TQ_IDLE: begin
            if (start_go) begin
              st  <= TQ_FETCH;
              ptr <= first_ptr;
            end
          end
          TQ_FETCH: begin
            if (fetch_ready) st <= TQ_WDESC;
          end
          TQ_WDESC: begin
            if (stop_pend) begin
              st     <= TQ_IDLE;
              tx_end <= 1'b1;
            end else if (desc_valid) begin
              if (desc_own) begin
                st <= TQ_SEND;
              end else begin
                st     <= TQ_IDLE;
                tx_end <= 1'b1;
              end
            end
          end
          TQ_SEND: begin
            if (frame_end) begin
              if (stop_pend) begin
                st     <= TQ_IDLE;
                tx_end <= 1'b1;
              end else begin
                st <= TQ_WDESC;
              end
            end
          end
          default: st <= TQ_IDLE;
        endcase
      end
    end
  end

  assign fetch_valid = (st == TQ_FETCH);
  assign fetch_addr  = ptr;
  assign desc_ready  = (st == TQ_WDESC) && !stop_pend;
  assign running     = (st != TQ_IDLE);
endmodule

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs #(
  parameter int NQ = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [NQ-1:0] start,
  input  logic [NQ-1:0] stop,
  input  logic          abort_tx,
  input  logic          rx_en_set,
  input  logic          abort_rx,
  input  logic          tx_idle,
  input  logic          rx_idle,
  output logic [NQ-1:0] start_bits,
  output logic [NQ-1:0] stop_bits,
  output logic [NQ-1:0] start_go,
  output logic          abort_go,
  output logic          tx_abort_busy,
  output logic          rx_enable,
  output logic          rx_abort_busy
);
  logic start_ok;

  assign abort_go = we && abort_tx;
  assign start_ok = we && !abort_tx && !tx_abort_busy;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign start_go[q] = start_ok && start[q] && !stop[q];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_bits[q] <= 1'b0;
        stop_bits[q]  <= 1'b0;
      end else if (abort_go) begin
        start_bits[q] <= 1'b0;
      end else if (we && stop[q]) begin
        stop_bits[q]  <= 1'b1;
        start_bits[q] <= 1'b0;
      end else if (start_go[q]) begin
        start_bits[q] <= 1'b1;
        stop_bits[q]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_abort_busy <= 1'b0;
    end else if (abort_go) begin
      tx_abort_busy <= 1'b1;
    end else if (tx_abort_busy && tx_idle) begin
      tx_abort_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_abort_busy <= 1'b0;
      rx_enable     <= 1'b0;
    end else if (we && abort_rx) begin
      rx_abort_busy <= 1'b1;
    end else if (rx_abort_busy && rx_idle) begin
      rx_abort_busy <= 1'b0;
      rx_enable     <= 1'b0;
    end else if (we && rx_en_set && !rx_abort_busy) begin
      rx_enable <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_qcmd_ctrl.sv
module dma_qcmd_ctrl #(
  parameter int NQ = 2,
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [NQ-1:0]    cmd_start,
  input  logic [NQ-1:0]    cmd_stop,
  input  logic             cmd_abort_tx,
  input  logic             cmd_rx_en,
  input  logic             cmd_abort_rx,
  input  logic [RW-1:0]    retry_limit,
  input  logic [NQ*AW-1:0] first_ptr,
  input  logic             tx_engine_idle,
  input  logic             rx_engine_idle,
  output logic [NQ-1:0]    fetch_valid,
  input  logic [NQ-1:0]    fetch_ready,
  output logic [NQ*AW-1:0] fetch_addr,
  input  logic [NQ-1:0]    desc_valid,
  input  logic [NQ-1:0]    desc_dma_own,
  output logic [NQ-1:0]    desc_ready,
  input  logic [NQ-1:0]    frame_done,
  input  logic [NQ-1:0]    tx_fail,
  output logic [NQ-1:0]    retry_req,
  output logic [NQ-1:0]    close_rl,
  output logic [NQ-1:0]    tx_end,
  output logic [NQ-1:0]    q_running,
  output logic [NQ-1:0]    q_start_bit,
  output logic [NQ-1:0]    q_stop_bit,
  output logic             tx_abort_busy,
  output logic             rx_enable,
  output logic             rx_abort_busy
);
  logic [NQ-1:0] start_go;
  logic          abort_go;

  dma_cmd_regs #(.NQ(NQ)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .we            (cmd_we),
    .start         (cmd_start),
    .stop          (cmd_stop),
    .abort_tx      (cmd_abort_tx),
    .rx_en_set     (cmd_rx_en),
    .abort_rx      (cmd_abort_rx),
    .tx_idle       (tx_engine_idle),
    .rx_idle       (rx_engine_idle),
    .start_bits    (q_start_bit),
    .stop_bits     (q_stop_bit),
    .start_go      (start_go),
    .abort_go      (abort_go),
    .tx_abort_busy (tx_abort_busy),
    .rx_enable     (rx_enable),
    .rx_abort_busy (rx_abort_busy)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_txq
    dma_txq_fsm #(.AW(AW), .RW(RW)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_go    (start_go[q]),
      .stop_pend   (q_stop_bit[q]),
      .abort_go    (abort_go),
      .first_ptr   (first_ptr[q*AW +: AW]),
      .retry_limit (retry_limit),
      .fetch_ready (fetch_ready[q]),
      .desc_valid  (desc_valid[q]),
      .desc_own    (desc_dma_own[q]),
      .frame_done  (frame_done[q]),
      .tx_fail     (tx_fail[q]),
      .fetch_valid (fetch_valid[q]),
      .fetch_addr  (fetch_addr[q*AW +: AW]),
      .desc_ready  (desc_ready[q]),
      .retry_req   (retry_req[q]),
      .close_rl    (close_rl[q]),
      .tx_end      (tx_end[q]),
      .running     (q_running[q])
    );
  end
endmodule

// File: rtl/dma_qcmd_ctrl_chk.sv
module dma_qcmd_ctrl_chk #(
  parameter int NQ = 2,
  parameter int AW = 32,
  parameter int RW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [NQ-1:0]    cmd_start,
  input logic [NQ-1:0]    cmd_stop,
  input logic             cmd_abort_tx,
  input logic [NQ*AW-1:0] first_ptr,
  input logic             tx_engine_idle,
  input logic             rx_engine_idle,
  input logic [NQ-1:0]    fetch_valid,
  input logic [NQ-1:0]    fetch_ready,
  input logic [NQ*AW-1:0] fetch_addr,
  input logic [NQ-1:0]    retry_req,
  input logic [NQ-1:0]    close_rl,
  input logic [NQ-1:0]    tx_end,
  input logic [NQ-1:0]    q_running,
  input logic [NQ-1:0]    q_start_bit,
  input logic [NQ-1:0]    q_stop_bit,
  input logic             tx_abort_busy,
  input logic             rx_enable,
  input logic             rx_abort_busy
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_start[q] && !cmd_stop[q] && !cmd_abort_tx && !tx_abort_busy && !q_running[q])
      |=> (q_running[q] && fetch_valid[q] && fetch_addr[q*AW +: AW] == $past(first_ptr[q*AW +: AW]))); // R1
    AST_BITS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({q_start_bit[q], q_stop_bit[q]})); // R2
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid[q] && !fetch_ready[q] && !(cmd_we && cmd_abort_tx))
      |=> (fetch_valid[q] && $stable(fetch_addr[q*AW +: AW]))); // R3
    AST_END_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end[q] |-> (!q_running[q] && $past(q_running[q]))); // R7
    AST_RETRY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(retry_req[q] && close_rl[q])); // R8
    AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !cmd_start[q] && !cmd_stop[q] && !cmd_abort_tx)
      |=> ($stable(q_start_bit[q]) && $stable(q_stop_bit[q]))); // R2
  end

  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_abort_tx) |=> (q_running == '0 && tx_end == '0 && close_rl == '0 && tx_abort_busy)); // R10
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort_busy && !tx_engine_idle) |=> tx_abort_busy); // R10
  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort_busy && tx_engine_idle && !(cmd_we && cmd_abort_tx)) |=> !tx_abort_busy); // R10
  AST_ABORT_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort_busy && $past(tx_abort_busy)) |-> (q_running == '0)); // R11
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_abort_busy && rx_engine_idle) |=> (!rx_enable && !rx_abort_busy)); // R12
endmodule

bind dma_qcmd_ctrl dma_qcmd_ctrl_chk #(.NQ(NQ), .AW(AW), .RW(RW)) u_chk (.*);

// File: tb/tb_dma_qcmd_ctrl.sv
`timescale 1ns/1ps
module tb_dma_qcmd_ctrl;
  localparam int NQ = 2;
  localparam int AW = 32;
  localparam int RW = 4;
  localparam int NV = 5;
  // retry table: limit, failures issued, expected retries, expected limit closes
  localparam int V_LIM [NV] = '{3, 1, 0, 15, 5};
  localparam int V_FAIL[NV] = '{4, 2, 20, 16, 2};
  localparam int V_RTY [NV] = '{3, 1, 20, 15, 2};
  localparam int V_RL  [NV] = '{1, 1, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 0, cmd_abort_tx = 0, cmd_rx_en = 0, cmd_abort_rx = 0;
  logic [NQ-1:0] cmd_start = '0, cmd_stop = '0;
  logic [RW-1:0] retry_limit = '0;
  logic [NQ*AW-1:0] first_ptr = {32'h0000_2200, 32'h0000_1100};
  logic tx_engine_idle = 0, rx_engine_idle = 0;
  logic [NQ-1:0] fetch_ready = '0, desc_valid = '0, desc_dma_own = '0;
  logic [NQ-1:0] frame_done = '0, tx_fail = '0;
  logic [NQ-1:0] fetch_valid, desc_ready, retry_req, close_rl, tx_end;
  logic [NQ-1:0] q_running, q_start_bit, q_stop_bit;
  logic [NQ*AW-1:0] fetch_addr;
  logic tx_abort_busy, rx_enable, rx_abort_busy;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dma_qcmd_ctrl #(.NQ(NQ), .AW(AW), .RW(RW)) dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [NQ-1:0] s, input logic [NQ-1:0] p, input logic ab);
    cmd_we = 1; cmd_start = s; cmd_stop = p; cmd_abort_tx = ab;
    tick();
    cmd_we = 0; cmd_start = '0; cmd_stop = '0; cmd_abort_tx = 0;
  endtask

  // start queue q and bring it to the sending state
  task automatic to_send(input int q);
    wr(NQ'(1 << q), '0, 0);
    fetch_ready[q] = 1; tick(); fetch_ready[q] = 0;
    desc_valid[q] = 1; desc_dma_own[q] = 1; tick();
    desc_valid[q] = 0; desc_dma_own[q] = 0;
  endtask

  task automatic end_chain(input int q, input string req);
    desc_valid[q] = 1; desc_dma_own[q] = 0; tick(); desc_valid[q] = 0;
    chk({req, " end pulse"}, tx_end[q], 1);
    chk({req, " running off"}, q_running[q], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int nr, nl;
    tick(); tick();
    rst_n = 1; tick();
    // reset state
    chk("reset running", q_running, 0);
    chk("reset fetch", fetch_valid, 0);
    chk("reset busy", {tx_abort_busy, rx_enable, rx_abort_busy}, 0);

    // table: retry behaviour R8 / R9
    for (int v = 0; v < NV; v++) begin
      retry_limit = RW'(V_LIM[v]);
      to_send(0);
      nr = 0; nl = 0;
      for (int i = 0; i < V_FAIL[v]; i++) begin
        tx_fail[0] = 1; tick();
        nr += int'(retry_req[0]); nl += int'(close_rl[0]);
      end
      tx_fail[0] = 0;
      chk($sformatf("R8 R9 retries lim=%0d", V_LIM[v]), nr, V_RTY[v]);
      chk($sformatf("R8 R9 closes lim=%0d", V_LIM[v]), nl, V_RL[v]);
      if (V_RL[v] == 0) begin
        frame_done[0] = 1; tick(); frame_done[0] = 0;
        chk("R8 frame end no event", tx_end[0], 0);
      end
      chk("R8 awaiting next descriptor", desc_ready[0], 1);
      end_chain(0, "R7");
    end
    retry_limit = 4'd2;

    // R5 stop on idle queue, R2 zero write and stop priority
    wr(2'b00, 2'b01, 0);
    chk("R5 idle stop no event", tx_end[0], 0);
    chk("R2 stop bit set", q_stop_bit[0], 1);
    wr(2'b00, 2'b00, 0);
    chk("R2 zero write keeps stop", q_stop_bit[0], 1);
    chk("R2 zero write keeps start", q_start_bit[0], 0);
    wr(2'b10, 2'b10, 0);
    chk("R2 stop wins start", {q_start_bit[1], q_stop_bit[1], q_running[1]}, 3'b010);

    // R1 start, R3 fetch hold
    wr(2'b01, 2'b00, 0);
    chk("R1 start bits", {q_start_bit[0], q_stop_bit[0]}, 2'b10);
    chk("R1 running", q_running[0], 1);
    chk("R1 fetch addr", fetch_addr[AW-1:0], 32'h0000_1100);
    tick();
    chk("R3 fetch held", {fetch_valid[0], desc_ready[0]}, 2'b10);
    chk("R3 addr held", fetch_addr[AW-1:0], 32'h0000_1100);
    fetch_ready[0] = 1; tick(); fetch_ready[0] = 0;
    chk("R3 desc ready after accept", {fetch_valid[0], desc_ready[0]}, 2'b01);

    // R5 stop while awaiting descriptor
    wr(2'b00, 2'b01, 0);
    chk("R5 stop bit then still running", q_running[0], 1);
    tick();
    chk("R5 end pulse", tx_end[0], 1);
    chk("R5 running off", q_running[0], 0);

    // R4 stop deferred to frame end
    to_send(0);
    wr(2'b00, 2'b01, 0);
    tick(); tick();
    chk("R4 still running mid frame", {q_running[0], tx_end[0]}, 2'b10);
    frame_done[0] = 1; tick(); frame_done[0] = 0;
    chk("R4 end pulse", tx_end[0], 1);
    chk("R4 running off", q_running[0], 0);
    tick();
    chk("R4 pulse one cycle", tx_end[0], 0);

    // R6 start cancels pending stop
    to_send(0);
    wr(2'b00, 2'b01, 0);
    wr(2'b01, 2'b00, 0);
    chk("R6 stop cleared no refetch", {q_stop_bit[0], fetch_valid[0]}, 2'b00);
    frame_done[0] = 1; tick(); frame_done[0] = 0;
    chk("R6 no end event", tx_end[0], 0);
    chk("R6 continues", {q_running[0], desc_ready[0]}, 2'b11);

    // R13 independence: queue 1 ends while queue 0 runs
    wr(2'b10, 2'b00, 0);
    fetch_ready[1] = 1; tick(); fetch_ready[1] = 0;
    end_chain(1, "R13 q1");
    chk("R13 q0 unaffected", {q_running[0], tx_end[0]}, 2'b10);
    end_chain(0, "R13 q0");

    // R10 abort with one queue sending, the other fetching
    to_send(0);
    wr(2'b10, 2'b00, 0);
    chk("R10 q1 fetching", fetch_valid[1], 1);
    wr(2'b00, 2'b00, 1);
    chk("R10 all idle", {q_running, fetch_valid}, 0);
    chk("R10 no events", {tx_end, close_rl}, 0);
    chk("R10 start bits cleared", q_start_bit, 0);
    chk("R10 busy", tx_abort_busy, 1);
    tick();
    chk("R10 busy held", tx_abort_busy, 1);
    wr(2'b01, 2'b00, 0);
    chk("R11 start ignored", {q_running[0], q_start_bit[0]}, 2'b00);
    frame_done[0] = 1; tick(); frame_done[0] = 0;
    chk("R10 late frame done ignored", tx_end[0], 0);
    tx_engine_idle = 1; tick(); tx_engine_idle = 0;
    chk("R10 busy clears", tx_abort_busy, 0);
    wr(2'b01, 2'b00, 1);
    chk("R11 start with abort ignored", q_running[0], 0);
    tx_engine_idle = 1; tick(); tx_engine_idle = 0;

    // R12 receive enable and abort
    cmd_we = 1; cmd_rx_en = 1; tick(); cmd_we = 0; cmd_rx_en = 0;
    chk("R12 rx enabled", rx_enable, 1);
    cmd_we = 1; cmd_abort_rx = 1; tick(); cmd_we = 0; cmd_abort_rx = 0;
    chk("R12 rx abort busy", {rx_enable, rx_abort_busy}, 2'b11);
    tick();
    chk("R12 rx busy held", rx_abort_busy, 1);
    rx_engine_idle = 1; tick(); rx_engine_idle = 0;
    chk("R12 rx cleared", {rx_enable, rx_abort_busy}, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule